// File: doc/BRIEF.md
# Prefetch Chip-Select Idle Timeout

This block watches the read path of a serial flash controller while it runs in its memory-mapped (execute-in-place) mode. After the prefetch FIFO has filled, the controller keeps the flash selected and streaming. Holding chip select low costs power, so this timer counts the clock cycles that pass without a bus access. When that count reaches a programmed 16-bit limit, the timer asks the protocol engine to end the read. It does this by releasing the active-low chip select.

The timer starts only on the cycle in which the FIFO goes from not full to full. Any bus access stops the count, and counting resumes only at the next fill event. The release request is a single-cycle pulse. A sticky timeout flag records that a release took place, and software clears it with a write. The enable bit is captured only while the engine reports that it is not busy. The protocol engine itself lies outside this block.

Top module: `cs_idle_timeout`

## Requirements
- R1: The timer works only while `mmap_mode_i` is 1. A cycle with `mmap_mode_i` = 0 produces no `cs_release_o` pulse in the following cycle.
- R2: While the captured enable is 0, `cs_release_o` never pulses, so chip select is held indefinitely.
- R3: Let cycle C be the cycle in which `fifo_full_i` rises and let L be `timeout_i`. If no access occurs in cycles C through C+L, `cs_release_o` is 1 in cycle C+1+L. It is 0 in every other cycle of that run.
- R4: Counting starts only on a 0-to-1 transition of `fifo_full_i`. A FIFO that stays full does not start a new count after a release, and neither does entering memory-mapped mode while the FIFO is already full.
- R5: `timeout_en_i` is captured into the internal enable only on cycles with `busy_i` = 0. Changes made while `busy_i` = 1 have no effect.
- R6: An `access_i` cycle clears the count, and that run produces no release. A new count starts only at the next rising `fifo_full_i`, including when the access falls in cycle C itself.
- R7: `cs_release_o` is a one-cycle pulse. `timeout_flag_o` is 1 in the same cycle as the pulse and stays 1 until a `flag_clr_i` cycle, after which it reads 0.
- R8: With `timeout_i` = 0, the release comes in the cycle right after the FIFO-full edge, provided no access occurs in the edge cycle.
- R9: A cycle with `mmap_mode_i` = 0 resets the count to 0. Returning to memory-mapped mode does not resume the earlier count.
- R10: If `flag_clr_i` falls in the same cycle as a timeout, the set wins and `timeout_flag_o` reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmap_mode_i | input | 1 | Engine is in memory-mapped mode |
| busy_i | input | 1 | Engine busy; blocks enable capture |
| timeout_en_i | input | 1 | Requested timeout enable |
| timeout_i | input | 16 | Idle-cycle limit |
| fifo_full_i | input | 1 | Prefetch FIFO is full |
| access_i | input | 1 | Bus access to flash space this cycle |
| flag_clr_i | input | 1 | Write strobe that clears the timeout flag |
| cs_release_o | output | 1 | One-cycle request to release chip select |
| timeout_flag_o | output | 1 | Sticky timeout indication |

## Verification
The assertions check the following on every cycle:
- No release follows a cycle outside memory-mapped mode or with the enable off.
- The enable stays put while the engine is busy.
- An access or a mode exit empties the counter.
- Every release coincides with a set flag.
- The flag holds until a clear arrives.

Some behaviour only the bench scenarios can show:
- The exact release cycle for each limit and each access position.
- That a FIFO which stays full does not restart the count.
- That a count interrupted by a mode exit is not resumed.
- That a set wins over a clear arriving in the same cycle.

// File: rtl/cs_idle_pkg.sv
package cs_idle_pkg;

  localparam int unsigned CS_IDLE_CNT_W = 16;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_COUNT = 1'b1
  } idle_state_e;

endpackage

// File: rtl/cs_idle_cfg.sv
module cs_idle_cfg (
  input  logic clk,
  input  logic rst,
  input  logic mmap_mode_i,
  input  logic busy_i,
  input  logic timeout_en_i,
  input  logic fifo_full_i,
  output logic en_q_o,
  output logic gate_o,
  output logic full_rise_o
);

  logic en_q;
  logic full_d;

  // Enable capture is allowed only while the engine is idle.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (!busy_i) begin
      en_q <= timeout_en_i;
    end
  end

  // Remember last cycle's FIFO-full level for edge detection.
  always_ff @(posedge clk) begin
    if (rst) begin
      full_d <= 1'b0;
    end else begin
      full_d <= fifo_full_i;
    end
  end

  assign en_q_o      = en_q;
  assign gate_o      = mmap_mode_i && en_q;
  assign full_rise_o = fifo_full_i && !full_d;

  AST_EN_HOLD_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(en_q)); // R5

endmodule

// File: rtl/cs_idle_count.sv
module cs_idle_count
  import cs_idle_pkg::*;
#(
  parameter int unsigned CNT_W = CS_IDLE_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gate_i,
  input  logic             mmap_mode_i,
  input  logic             start_i,
  input  logic             access_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             fire_o
);

  idle_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cur;
  logic             live;

  // A fresh edge restarts from zero, otherwise continue the running count.
  always_comb begin
    cur    = start_i ? '0 : cnt_q;
    live   = (start_i || (state_q == ST_COUNT)) && gate_i && !access_i;
    fire_o = live && (cur >= limit_i);
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (!gate_i || access_i || fire_o) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (live) begin
      state_d = ST_COUNT;
      cnt_d   = cur + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    access_i |=> (cnt_q == '0 && state_q == ST_IDLE)); // R6

  AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !mmap_mode_i |=> (cnt_q == '0 && state_q == ST_IDLE)); // R9

endmodule

// File: rtl/cs_idle_out.sv
module cs_idle_out (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic flag_clr_i,
  output logic release_o,
  output logic flag_o
);

  logic rel_q;
  logic flag_q;

  // Outputs are registered; a set outranks a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      rel_q  <= fire_i;
      flag_q <= fire_i || (flag_q && !flag_clr_i);
    end
  end

  assign release_o = rel_q;
  assign flag_o    = flag_q;

  AST_REL_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    release_o |-> flag_o); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !flag_clr_i) |=> flag_o); // R7

endmodule

// File: rtl/cs_idle_timeout.sv
module cs_idle_timeout
  import cs_idle_pkg::*;
#(
  parameter int unsigned CNT_W = CS_IDLE_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mmap_mode_i,
  input  logic             busy_i,
  input  logic             timeout_en_i,
  input  logic [CNT_W-1:0] timeout_i,
  input  logic             fifo_full_i,
  input  logic             access_i,
  input  logic             flag_clr_i,
  output logic             cs_release_o,
  output logic             timeout_flag_o
);

  logic en_q;
  logic gate;
  logic full_rise;
  logic fire;

  cs_idle_cfg i_cfg (
    .clk          (clk),
    .rst          (rst),
    .mmap_mode_i  (mmap_mode_i),
    .busy_i       (busy_i),
    .timeout_en_i (timeout_en_i),
    .fifo_full_i  (fifo_full_i),
    .en_q_o       (en_q),
    .gate_o       (gate),
    .full_rise_o  (full_rise)
  );

  cs_idle_count #(.CNT_W(CNT_W)) i_count (
    .clk         (clk),
    .rst         (rst),
    .gate_i      (gate),
    .mmap_mode_i (mmap_mode_i),
    .start_i     (full_rise),
    .access_i    (access_i),
    .limit_i     (timeout_i),
    .fire_o      (fire)
  );

  cs_idle_out i_out (
    .clk        (clk),
    .rst        (rst),
    .fire_i     (fire),
    .flag_clr_i (flag_clr_i),
    .release_o  (cs_release_o),
    .flag_o     (timeout_flag_o)
  );

  AST_MODE_NO_REL: assert property (@(posedge clk) disable iff (rst)
    !mmap_mode_i |=> !cs_release_o); // R1

  AST_DIS_NO_REL: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !cs_release_o); // R2

endmodule

// File: tb/test_cs_idle_timeout.sv
module test_cs_idle_timeout;

  logic        clk = 1'b0;
  logic        rst;
  logic        mmap_mode_i;
  logic        busy_i;
  logic        timeout_en_i;
  logic [15:0] timeout_i;
  logic        fifo_full_i;
  logic        access_i;
  logic        flag_clr_i;
  logic        cs_release_o;
  logic        timeout_flag_o;

  int checks   = 0;
  int failures = 0;

  always #4 clk = ~clk;

  cs_idle_timeout i_cs_idle_timeout (
    .clk            (clk),
    .rst            (rst),
    .mmap_mode_i    (mmap_mode_i),
    .busy_i         (busy_i),
    .timeout_en_i   (timeout_en_i),
    .timeout_i      (timeout_i),
    .fifo_full_i    (fifo_full_i),
    .access_i       (access_i),
    .flag_clr_i     (flag_clr_i),
    .cs_release_o   (cs_release_o),
    .timeout_flag_o (timeout_flag_o)
  );

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_flag();
    flag_clr_i = 1'b1;
    tick();
    flag_clr_i = 1'b0;
  endtask

  // Drive one FIFO-fill run with the given limit and optional access cycle
  // (acc < 0 means none). Sample outputs at every negedge before driving.
  task automatic run(input int lim, input int acc, input bit fire_ok, input bit keep_full,
                     input string tag);
    bit exp_fire;
    if (!keep_full) begin
      fifo_full_i = 1'b0;
      tick();
      tick();
    end
    timeout_i = lim[15:0];
    exp_fire  = fire_ok && (acc < 0 || acc > lim);
    for (int k = 0; k <= lim + 3; k++) begin
      if (k >= 1) check(cs_release_o, exp_fire && (k == lim + 1), tag);
      if (k == lim + 1 && exp_fire) check(timeout_flag_o, 1'b1, "R7 flag with pulse");
      fifo_full_i = 1'b1;
      access_i    = (k == acc);
      tick();
    end
    access_i = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; mmap_mode_i = 1'b1; busy_i = 1'b0; timeout_en_i = 1'b1;
    timeout_i = 16'd0; fifo_full_i = 1'b0; access_i = 1'b0; flag_clr_i = 1'b0;
    tick(); tick();
    check(cs_release_o, 1'b0, "reset release");
    check(timeout_flag_o, 1'b0, "reset flag");
    rst = 1'b0;
    tick();

    // R3 / R6 / R8: sweep limits and access positions
    for (int lim = 0; lim <= 12; lim++) begin
      run(lim, -1, 1'b1, 1'b0, (lim == 0) ? "R8 zero limit" : "R3 idle release");
      clear_flag();
      check(timeout_flag_o, 1'b0, "R7 flag cleared");
      for (int a = 0; a <= lim; a++) begin
        run(lim, a, 1'b1, 1'b0, "R6 access cancels");
        check(timeout_flag_o, 1'b0, "R6 no flag after access");
      end
    end

    // R7: flag sticky over idle cycles
    run(3, -1, 1'b1, 1'b0, "R3 release");
    for (int i = 0; i < 5; i++) begin
      check(timeout_flag_o, 1'b1, "R7 sticky flag");
      tick();
    end
    clear_flag();
    check(timeout_flag_o, 1'b0, "R7 flag cleared");

    // R4: FIFO stays full -> no new count
    run(2, -1, 1'b1, 1'b0, "R3 release");
    run(2, -1, 1'b0, 1'b1, "R4 no restart while full");
    clear_flag();

    // R4: enter mmap while full -> nothing
    mmap_mode_i = 1'b0; fifo_full_i = 1'b1; tick(); tick();
    mmap_mode_i = 1'b1; timeout_i = 16'd0;
    for (int i = 0; i < 6; i++) begin
      tick();
      check(cs_release_o, 1'b0, "R4 full before mode entry");
    end

    // R1: not in mmap mode
    mmap_mode_i = 1'b0;
    run(4, -1, 1'b0, 1'b0, "R1 mode gate");
    check(timeout_flag_o, 1'b0, "R1 no flag");
    mmap_mode_i = 1'b1;

    // R9: drop mmap mid count, return, no resume
    fifo_full_i = 1'b0; tick(); tick();
    timeout_i = 16'd5;
    fifo_full_i = 1'b1; tick(); tick();
    mmap_mode_i = 1'b0; tick();
    mmap_mode_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      tick();
      check(cs_release_o, 1'b0, "R9 no resume");
    end

    // R5: enable changes while busy are ignored
    busy_i = 1'b1; timeout_en_i = 1'b0; tick();
    run(3, -1, 1'b1, 1'b0, "R5 busy holds enable");
    clear_flag();
    busy_i = 1'b0; tick();
    busy_i = 1'b1; timeout_en_i = 1'b1; tick();
    // R2: disabled -> no release
    run(0, -1, 1'b0, 1'b0, "R2 disabled");
    run(6, -1, 1'b0, 1'b0, "R2 disabled");
    check(timeout_flag_o, 1'b0, "R2 no flag");
    busy_i = 1'b0; tick();

    // R10: clear in the firing cycle loses to set
    fifo_full_i = 1'b0; tick(); tick();
    timeout_i = 16'd2;
    fifo_full_i = 1'b1; tick();   // cycle 0
    tick();                        // cycle 1
    flag_clr_i = 1'b1; tick();     // cycle 2 fires
    flag_clr_i = 1'b0;
    check(cs_release_o, 1'b1, "R10 pulse");
    check(timeout_flag_o, 1'b1, "R10 set wins");
    tick();
    check(cs_release_o, 1'b0, "R7 single pulse");
    clear_flag();
    check(timeout_flag_o, 1'b0, "R7 flag cleared");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule